// File: doc/BRIEF.md
# Programmable Down-Counter with Count Latch

This block is a single 16-bit divider channel driven from an 8-bit register bus. Software writes a divisor N as two bytes. The channel then counts down on each count tick and gives one output pulse every N ticks. A gate input stops the count, so a plain read of the live value returns a settled number.

The main feature is a latch command. A control word written to the control address copies the running count into a holding register, and counting goes on. Software then reads the frozen value as a low byte followed by a high byte. The holding register stays frozen until its high byte has been read. Every bus access and the count tick are synchronous to `clk`. `cnt_tick` is a one-cycle enable that stands for an edge of the counting clock.

Address map: 0 is the data port, 3 is the control port, and 1 and 2 are not decoded. Control word layout: bits [7:6] pick the channel, which must equal `CH_SEL` (default 1). If bits [5:4] are 00 the word is a latch command. Any other value of bits [5:4] is a mode word.

Top module: `cnt_latch_divider`

## Requirements
- R1: Reset behaviour. After a synchronous active-low reset `div_out` is 0, no latch is pending, both byte pointers point at the low byte, and the live count reads back as 0x00 then 0x00.
- R2: Loading N. Two byte writes to address 0 set N, low byte first and high byte second. The new count is loaded on the first `cnt_tick` after the high byte is written, whatever the level of `gate`.
- R3: Gate. While `gate` is 1, each `cnt_tick` lowers a loaded count by one. While `gate` is 0, ticks leave the count unchanged and `div_out` stays 0.
- R4: Output pulse. When a tick arrives while the count is 1, the count reloads N and `div_out` goes high for exactly one `clk` cycle. The result is one pulse every N ticks.
- R5: Zero divisor. N = 0 loads as 0x0000. The next tick takes it to 0xFFFF, which gives a period of 65536 ticks.
- R6: Latch capture. A latch command (for example 0x40 for channel 1) copies the current count into the holding register, and counting continues.
- R7: Read order and release. A read from address 0 returns the low byte first and the high byte second. Reading the high byte of a latched value releases the latch, so later reads return the live count.
- R8: Repeated latch. A latch command that arrives while a latched value is still unread is ignored.
- R9: Control words. A control word whose bits [7:6] do not equal `CH_SEL` has no effect. A mode word for this channel (bits [5:4] not 00) resets both byte pointers to the low byte and discards any pending latch.
- R10: Bus decode. Writes are ignored when `bus_cs` is 0 or when they go to address 1 or 2. A latch word written to address 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select |
| bus_addr | input | 2 | Register address: 0 is data, 3 is control |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the byte the read pointer selects |
| cnt_tick | input | 1 | One-cycle enable for each edge of the counting clock |
| gate | input | 1 | Count enable |
| div_out | output | 1 | One-cycle pulse every N ticks |

## Verification
The divider is run with a small divisor (4), a medium divisor (8) and the zero divisor. These three show a correct reload period, a pointer that was correctly reset before a load, and the wrap from 0 to 0xFFFF. Latched reads are taken while the count keeps moving: one plain latch, one latch followed by an ignored second latch, and one latch aimed at a different channel. Each of these gives a different byte if the capture, the freeze or the selector decode is wrong. Half-finished reads, followed by mode words for this channel or for another channel, show whether the pointer reset happens only when it should. Writes made with the chip deselected or to unused addresses would move the write pointer or change N if they were not ignored.

// File: rtl/cnt_latch_pkg.sv
// Package: shared widths, address codes and control-word fields for the
// latched down-counter channel.
package cnt_latch_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd3
    } reg_addr_e;

    // Bits of a control word that pick the access kind; 00 means latch.
    localparam logic [1:0] ACC_LATCH = 2'b00;
endpackage

// File: rtl/cnt_bus_decode.sv
// Bus decode: turns strobes into single-cycle commands and keeps the
// divisor with its write byte pointer.
// Assumes: no read and write in the same cycle; strobes last one cycle.
module cnt_bus_decode
    import cnt_latch_pkg::*;
#(
    parameter logic [1:0] CH_SEL = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              load_ack,
    output logic [CNT_W-1:0]  n_val,
    output logic              load_req,
    output logic              latch_cmd,
    output logic              mode_cmd,
    output logic              rd_go
);
    logic                data_wr;
    logic                ctrl_wr;
    logic                sel_hit;
    logic                wr_ptr;
    logic [BYTE_W-1:0]   lsb_q;

    // Command decode from the bus strobes.
    always_comb begin
        data_wr   = bus_cs && bus_wr && (bus_addr == REG_DATA);
        ctrl_wr   = bus_cs && bus_wr && (bus_addr == REG_CTRL);
        sel_hit   = (bus_wdata[7:6] == CH_SEL);
        latch_cmd = ctrl_wr && sel_hit && (bus_wdata[5:4] == ACC_LATCH);
        mode_cmd  = ctrl_wr && sel_hit && (bus_wdata[5:4] != ACC_LATCH);
        rd_go     = bus_cs && bus_rd && (bus_addr == REG_DATA);
    end

    // Write pointer, staged low byte, divisor and pending-load flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= 1'b0;
            lsb_q    <= '0;
            n_val    <= '0;
            load_req <= 1'b0;
        end else begin
            if (load_ack) load_req <= 1'b0;
            if (mode_cmd) begin
                wr_ptr <= 1'b0;
            end else if (data_wr) begin
                wr_ptr <= ~wr_ptr;
                if (!wr_ptr) begin
                    lsb_q <= bus_wdata;
                end else begin
                    n_val    <= {bus_wdata, lsb_q};
                    load_req <= 1'b1;
                end
            end
        end
    end

    // R2: a high-byte write always leaves a load pending
    assert_load_after_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && wr_ptr) |=> load_req);
endmodule

// File: rtl/cnt_count_core.sv
// Count core: the down-counter with reload and the output pulse.
// Assumes: cnt_tick is a one-cycle enable; a count of 0 stands for 65536.
module cnt_count_core
    import cnt_latch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             gate,
    input  logic             load_req,
    input  logic [CNT_W-1:0] n_in,
    output logic             load_ack,
    output logic [CNT_W-1:0] cnt_q,
    output logic             div_out
);
    logic [CNT_W-1:0] reload_q;
    logic             armed_q;
    logic             step;

    // A pending load takes the tick; otherwise a gated tick steps the count.
    always_comb begin
        load_ack = cnt_tick && load_req;
        step     = cnt_tick && !load_req && gate && armed_q;
    end

    // Counter, reload copy and one-cycle output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            armed_q  <= 1'b0;
            div_out  <= 1'b0;
        end else begin
            div_out <= 1'b0;
            if (load_ack) begin
                cnt_q    <= n_in;
                reload_q <= n_in;
                armed_q  <= 1'b1;
            end else if (step) begin
                if (cnt_q == CNT_W'(1)) begin
                    cnt_q   <= reload_q;
                    div_out <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R3: gate low and no load, the count holds
    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !load_ack) |=> $stable(cnt_q));
    // R4: a pulse is only seen right after a reload to N
    assert_pulse_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |-> (cnt_q == reload_q));
    // R5: zero wraps to all ones
    assert_zero_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == '0) |=> (cnt_q == '1));
endmodule

// File: rtl/cnt_read_port.sv
// Read port: the latch holding register, the read byte pointer and the
// read data mux.
// Assumes: commands from cnt_bus_decode are single-cycle pulses.
module cnt_read_port
    import cnt_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_cmd,
    input  logic              mode_cmd,
    input  logic              rd_go,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [BYTE_W-1:0] rdata
);
    logic [CNT_W-1:0] lat_val;
    logic             lat_vld;
    logic             rd_ptr;
    logic [CNT_W-1:0] src;

    // Pick the frozen value while a latch is pending, the live count otherwise.
    always_comb begin
        src   = lat_vld ? lat_val : cnt_q;
        rdata = rd_ptr ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

    // Latch capture, release after the high byte, and the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_val <= '0;
            lat_vld <= 1'b0;
            rd_ptr  <= 1'b0;
        end else if (mode_cmd) begin
            lat_vld <= 1'b0;
            rd_ptr  <= 1'b0;
        end else begin
            if (latch_cmd && !lat_vld) begin
                lat_val <= cnt_q;
                lat_vld <= 1'b1;
            end
            if (rd_go) begin
                rd_ptr <= ~rd_ptr;
                if (rd_ptr) lat_vld <= 1'b0;
            end
        end
    end

    // R8: a pending latched value never changes
    assert_latch_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_vld && $past(lat_vld)) |-> $stable(lat_val));
    // R7: reading the high byte releases the latch
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && rd_ptr && !latch_cmd) |=> !lat_vld);
endmodule

// File: rtl/cnt_latch_divider.sv
// Top: one programmable divide-by-N channel with count latch, on an 8-bit
// bus. Assumes all inputs are synchronous to clk.
module cnt_latch_divider
    import cnt_latch_pkg::*;
#(
    parameter logic [1:0] CH_SEL = 2'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_cs,
    input  logic [1:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        cnt_tick,
    input  logic        gate,
    output logic        div_out
);
    logic [CNT_W-1:0] n_val;
    logic [CNT_W-1:0] cnt_q;
    logic             load_req;
    logic             load_ack;
    logic             latch_cmd;
    logic             mode_cmd;
    logic             rd_go;

    cnt_bus_decode #(.CH_SEL(CH_SEL)) u_decode (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .load_ack(load_ack), .n_val(n_val), .load_req(load_req),
        .latch_cmd(latch_cmd), .mode_cmd(mode_cmd), .rd_go(rd_go)
    );

    cnt_count_core u_core (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate(gate),
        .load_req(load_req), .n_in(n_val), .load_ack(load_ack),
        .cnt_q(cnt_q), .div_out(div_out)
    );

    cnt_read_port u_read (
        .clk(clk), .rst_n(rst_n), .latch_cmd(latch_cmd), .mode_cmd(mode_cmd),
        .rd_go(rd_go), .cnt_q(cnt_q), .rdata(bus_rdata)
    );

    // R1: no pulse in the first cycle after reset
    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !div_out);
endmodule

// File: tb/test_cnt_latch_divider.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue the expected bytes, and a monitor
// compares them against bus_rdata at the falling edge.
module test_cnt_latch_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cnt_tick = 1'b0;
    logic       gate = 1'b0;
    logic       div_out;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    cnt_latch_divider i_cnt_latch_divider (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_tick(cnt_tick), .gate(gate),
        .div_out(div_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each data-port read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_cs && bus_rd && bus_addr == 2'd0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard-empty", bus_rdata, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input bit sel = 1'b1);
        @(posedge clk); #1;
        bus_cs = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_byte(input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = 2'd0;
        @(posedge clk); #1;
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic tick_n(input int k);
        @(posedge clk); #1;
        cnt_tick = 1'b1;
        repeat (k) @(posedge clk);
        #1 cnt_tick = 1'b0;
    endtask

    task automatic set_gate(input bit g);
        @(posedge clk); #1 gate = g;
    endtask

    // Cycles between two pulses while ticks come every cycle.
    task automatic period(input int exp, input string tag);
        int n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (div_out) break;
        end
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 100);
        check(n == exp, tag, n, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(div_out == 1'b0, "R1 div_out after reset", div_out, 0);
        rd_byte(8'h00, "R1 reset low byte");
        rd_byte(8'h00, "R1 reset high byte");

        // R2: load 0x1234 low byte first, load on next tick with gate low
        wr_reg(2'd0, 8'h34);
        wr_reg(2'd0, 8'h12);
        tick_n(1);
        rd_byte(8'h34, "R2 loaded low");
        rd_byte(8'h12, "R2 loaded high");
        // R3: ticks with gate low change nothing
        tick_n(5);
        rd_byte(8'h34, "R3 gate low hold low");
        rd_byte(8'h12, "R3 gate low hold high");
        set_gate(1'b1);
        tick_n(3);
        set_gate(1'b0);
        rd_byte(8'h31, "R3 three steps low");
        rd_byte(8'h12, "R3 three steps high");

        // R4: divide by 4
        wr_reg(2'd0, 8'h04);
        wr_reg(2'd0, 8'h00);
        set_gate(1'b1);
        @(posedge clk); #1 cnt_tick = 1'b1;
        period(4, "R4 period N=4 first");
        period(4, "R4 period N=4 second");
        set_gate(1'b0);
        repeat (2) @(posedge clk);
        begin
            int highs = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (div_out) highs++;
            end
            check(highs == 0, "R3 no pulse with gate low", highs, 0);
        end
        @(posedge clk); #1 cnt_tick = 1'b0;

        // R5: zero divisor
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd0, 8'h00);
        tick_n(1);
        rd_byte(8'h00, "R5 zero loaded low");
        rd_byte(8'h00, "R5 zero loaded high");
        set_gate(1'b1);
        tick_n(1);
        set_gate(1'b0);
        rd_byte(8'hFF, "R5 wrap low");
        rd_byte(8'hFF, "R5 wrap high");

        // R6/R7: latch while running
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd0, 8'h01);
        tick_n(1);
        set_gate(1'b1);
        tick_n(16);
        wr_reg(2'd3, 8'h40);
        tick_n(5);
        rd_byte(8'hF0, "R6 latched low");
        rd_byte(8'h00, "R7 latched high");
        rd_byte(8'hEB, "R7 live after release low");
        rd_byte(8'h00, "R7 live after release high");

        // R8: second latch ignored
        tick_n(3);
        wr_reg(2'd3, 8'h40);
        tick_n(2);
        wr_reg(2'd3, 8'h40);
        tick_n(2);
        rd_byte(8'hE8, "R8 first latch kept low");
        rd_byte(8'h00, "R8 first latch kept high");
        rd_byte(8'hE4, "R8 live low");
        rd_byte(8'h00, "R8 live high");

        // R9: foreign latch ignored, pointer handling on mode words
        wr_reg(2'd3, 8'h00);
        tick_n(1);
        rd_byte(8'hE3, "R9 foreign latch ignored");
        wr_reg(2'd3, 8'h30);
        rd_byte(8'h00, "R9 foreign mode keeps pointer");
        rd_byte(8'hE3, "R9 low before own mode");
        wr_reg(2'd3, 8'h70);
        rd_byte(8'hE3, "R9 own mode resets read pointer");
        rd_byte(8'h00, "R9 high after reset pointer");
        wr_reg(2'd0, 8'h55);
        wr_reg(2'd3, 8'h70);
        wr_reg(2'd0, 8'h08);
        wr_reg(2'd0, 8'h00);
        @(posedge clk); #1 cnt_tick = 1'b1;
        period(8, "R9 write pointer reset gives N=8");
        @(posedge clk); #1 cnt_tick = 1'b0;
        set_gate(1'b0);

        // R10: deselected and undecoded writes ignored
        wr_reg(2'd0, 8'h11, 1'b0);
        wr_reg(2'd1, 8'h99);
        wr_reg(2'd0, 8'h03);
        wr_reg(2'd0, 8'h00);
        tick_n(1);
        wr_reg(2'd2, 8'h40);
        set_gate(1'b1);
        tick_n(1);
        set_gate(1'b0);
        rd_byte(8'h02, "R10 ignored writes low");
        rd_byte(8'h00, "R10 ignored writes high");

        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule